// File: doc/BRIEF.md
# Carry-Driven Power-of-Two Clock Divider

This block divides an incoming clock by a power of two and reports the result as a one-cycle enable pulse. The divide setting is a 4-bit exponent, and the control loop cannot write it. The loop works on an 8-bit stage word instead. Each cycle it may request an add or a subtract of an 8-bit amount. A fine step is an amount of 1, and a coarse step is an amount of 32, a unit at stage bit 5.

The exponent moves only when the stage arithmetic leaves the 8-bit range:
- An add that overflows raises the exponent by one.
- A subtract that underflows lowers it by one.

In both cases the stage word keeps its wrapped low bits, so the combined frequency code (exponent above, stage word below) steps without a gap.

The exponent has a floor of 0 and a ceiling of 9. At either limit the stage word clamps instead of wrapping. Exponent codes above 9 behave exactly like 9. An exponent change takes effect only once the divide period in progress has finished.

Top module: `pow2_clkdiv`

## Requirements
- R1: After synchronous active-high reset, stage_q is 0, exp_q is 0 (with the default reset exponent), and div_en is high on every cycle.
- R2: For an effective exponent e in 0..9, div_en is high for exactly one cycle in every 2^e input cycles.
- R3: An exponent code from 10 to 15 acts as 9 in every respect. The period is 512. An overflowing add leaves exp_q unchanged and clamps the stage word. An underflowing subtract sets exp_q to 8.
- R4: An add (add_req=1, sub_req=0) that does not overflow sets stage_q to stage_q+amt and leaves exp_q unchanged. The coarse amount 32 is an ordinary add.
- R5: An add whose 9-bit sum exceeds 255 raises the exponent by one when the effective exponent is below 9. stage_q then takes the low 8 bits of the sum.
- R6: A subtract (sub_req=1, add_req=0) with amt > stage_q lowers the exponent by one when the effective exponent is above 0. stage_q then takes (stage_q-amt) mod 256. A subtract without underflow leaves exp_q unchanged.
- R7: At effective exponent 9, an overflowing add sets stage_q to 255 and leaves exp_q unchanged.
- R8: At exponent 0, an underflowing subtract sets stage_q to 0 and leaves exp_q at 0.
- R9: A cycle with add_req and sub_req both high changes neither stage_q nor exp_q.
- R10: A new exponent is applied only at a pulse. The period running when the exponent changes completes at its old length, and the next period has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| add_req | input | 1 | Add amt to the stage word this cycle |
| sub_req | input | 1 | Subtract amt from the stage word this cycle |
| amt | input | 8 | Step amount (1 fine, 32 coarse) |
| div_en | output | 1 | One-cycle enable per divided period |
| exp_q | output | 4 | Current divider exponent |
| stage_q | output | 8 | Current stage word |

## Verification
A stage word that wraps wrongly shows on stage_q in the cycle after the request. A missed or spurious carry shows on exp_q in that same cycle. A wrong exponent in the divider shows at div_en only after the running period ends, up to 512 cycles later. For that reason the bench measures whole pulse gaps instead of sampling single cycles. Saturation faults stay hidden until the exponent reaches a limit, so the tests drive the exponent through every code from 0 to 9. They also use a second instance that resets into the code range above 9.

// File: rtl/pow2_clkdiv_pkg.sv
`timescale 1ns/1ps
package pow2_clkdiv_pkg;
  localparam int EXP_W = 4;
  localparam int MASK_W = 16;
  typedef logic [EXP_W-1:0] exp_t;

  // Clamp a raw exponent code to the ceiling.
  function automatic exp_t sat_exp(input exp_t raw, input exp_t top);
    return (raw > top) ? top : raw;
  endfunction

  // Terminal count for a period of 2^e cycles.
  function automatic logic [MASK_W-1:0] period_mask(input exp_t e);
    return (MASK_W'(1) << e) - MASK_W'(1);
  endfunction
endpackage

// File: rtl/stage_accum.sv
`timescale 1ns/1ps
module stage_accum
  import pow2_clkdiv_pkg::*;
#(
  parameter int SW      = 8,
  parameter int MAX_EXP = 9,
  parameter int RST_EXP = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_req,
  input  logic          sub_req,
  input  logic [SW-1:0] amt,
  output logic [SW-1:0] stage_q,
  output exp_t          exp_q,
  output exp_t          eff_exp,
  output logic          carry_evt,
  output logic          borrow_evt
);
  localparam exp_t TOP = exp_t'(MAX_EXP);

  logic [SW:0]   sum_w, diff_w;
  logic          add_only, sub_only, at_top, at_floor;
  logic          clamp_hi, clamp_lo;
  logic [SW-1:0] stage_d;
  exp_t          exp_d;

  assign eff_exp  = sat_exp(exp_q, TOP);
  assign add_only = add_req & ~sub_req;
  assign sub_only = sub_req & ~add_req;
  assign sum_w    = {1'b0, stage_q} + {1'b0, amt};
  assign diff_w   = {1'b0, stage_q} - {1'b0, amt};
  assign at_top   = (eff_exp == TOP);
  assign at_floor = (eff_exp == '0);

  assign carry_evt  = add_only & sum_w[SW]  & ~at_top;
  assign borrow_evt = sub_only & diff_w[SW] & ~at_floor;
  assign clamp_hi   = add_only & sum_w[SW]  &  at_top;
  assign clamp_lo   = sub_only & diff_w[SW] &  at_floor;

  always_comb begin
    stage_d = stage_q;
    exp_d   = exp_q;
    if (add_only) begin
      stage_d = clamp_hi ? {SW{1'b1}} : sum_w[SW-1:0];
      if (carry_evt) exp_d = eff_exp + exp_t'(1);
    end else if (sub_only) begin
      stage_d = clamp_lo ? '0 : diff_w[SW-1:0];
      if (borrow_evt) exp_d = eff_exp - exp_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      exp_q   <= exp_t'(RST_EXP);
    end else begin
      stage_q <= stage_d;
      exp_q   <= exp_d;
    end
  end
endmodule

// File: rtl/pulse_divider.sv
`timescale 1ns/1ps
module pulse_divider
  import pow2_clkdiv_pkg::*;
#(
  parameter int MAX_EXP = 9,
  parameter int RST_EXP = 0
) (
  input  logic clk,
  input  logic rst,
  input  exp_t eff_in,
  output exp_t act_exp,
  output logic tick
);
  localparam int   CW  = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam exp_t TOP = exp_t'(MAX_EXP);

  logic [CW-1:0]     cnt;
  logic [MASK_W-1:0] mask_w;

  assign mask_w = period_mask(act_exp);
  assign tick   = (cnt == mask_w[CW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_exp <= sat_exp(exp_t'(RST_EXP), TOP);
    end else if (tick) begin
      cnt     <= '0;
      act_exp <= eff_in;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pow2_clkdiv.sv
`timescale 1ns/1ps
module pow2_clkdiv #(
  parameter int SW      = 8,
  parameter int MAX_EXP = 9,
  parameter int RST_EXP = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_req,
  input  logic          sub_req,
  input  logic [SW-1:0] amt,
  output logic          div_en,
  output logic [3:0]    exp_q,
  output logic [SW-1:0] stage_q
);
  import pow2_clkdiv_pkg::*;

  exp_t eff_exp, act_exp, exp_r;
  logic carry_evt, borrow_evt;

  stage_accum #(.SW(SW), .MAX_EXP(MAX_EXP), .RST_EXP(RST_EXP)) u_acc (
    .clk(clk), .rst(rst), .add_req(add_req), .sub_req(sub_req), .amt(amt),
    .stage_q(stage_q), .exp_q(exp_r), .eff_exp(eff_exp),
    .carry_evt(carry_evt), .borrow_evt(borrow_evt)
  );

  pulse_divider #(.MAX_EXP(MAX_EXP), .RST_EXP(RST_EXP)) u_div (
    .clk(clk), .rst(rst), .eff_in(eff_exp), .act_exp(act_exp), .tick(div_en)
  );

  assign exp_q = exp_r;
endmodule

// File: rtl/pow2_clkdiv_chk.sv
`timescale 1ns/1ps
module pow2_clkdiv_chk #(
  parameter int SW      = 8,
  parameter int MAX_EXP = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          add_req,
  input logic          sub_req,
  input logic [SW-1:0] amt,
  input logic [SW-1:0] stage_q,
  input logic [3:0]    exp_q,
  input logic [3:0]    eff_exp,
  input logic [3:0]    act_exp,
  input logic          carry_evt,
  input logic          borrow_evt,
  input logic          div_en
);
  logic [15:0] gap;
  always_ff @(posedge clk) begin
    if (rst || div_en) gap <= '0;
    else               gap <= gap + 16'd1;
  end

  // R2: every pulse closes a period of exactly 2^act cycles
  a_r2_period_len: assert property (@(posedge clk) disable iff (rst)
    div_en |-> (gap + 16'd1) == (16'd1 << act_exp));

  // R5 R6: the exponent moves only after a carry or borrow event
  a_r5_exp_moves_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && exp_q != $past(exp_q)) |-> $past(carry_evt || borrow_evt));

  // R5: a carry raises the effective exponent by one
  a_r5_carry_step: assert property (@(posedge clk) disable iff (rst)
    carry_evt |=> exp_q == $past(eff_exp) + 4'd1);

  // R7: an overflowing add at the ceiling clamps the stage word
  a_r7_ceiling_clamp: assert property (@(posedge clk) disable iff (rst)
    (add_req && !sub_req && eff_exp == 4'(MAX_EXP) &&
     ({1'b0, stage_q} + {1'b0, amt}) > 9'(2**SW - 1))
    |=> (stage_q == {SW{1'b1}}) && $stable(exp_q));

  // R9: simultaneous requests change nothing
  a_r9_both_idle: assert property (@(posedge clk) disable iff (rst)
    (add_req && sub_req) |=> $stable(stage_q) && $stable(exp_q));

  // R1: an exponent of zero gives a pulse every cycle
  a_r1_undivided: assert property (@(posedge clk) disable iff (rst)
    (act_exp == 4'd0) |-> div_en);
endmodule

bind pow2_clkdiv pow2_clkdiv_chk #(.SW(SW), .MAX_EXP(MAX_EXP)) u_chk (
  .clk(clk), .rst(rst), .add_req(add_req), .sub_req(sub_req), .amt(amt),
  .stage_q(stage_q), .exp_q(exp_q), .eff_exp(eff_exp), .act_exp(act_exp),
  .carry_evt(carry_evt), .borrow_evt(borrow_evt), .div_en(div_en)
);

// File: tb/sim_pow2_clkdiv.sv
`timescale 1ns/1ps
module sim_pow2_clkdiv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       a_add [2];
  logic       a_sub [2];
  logic [7:0] a_amt [2];
  logic       w_en  [2];
  logic [3:0] w_exp [2];
  logic [7:0] w_stg [2];

  int n_chk = 0;
  int n_err = 0;
  int m_stage [2];
  int m_exp   [2];

  always #10 clk = ~clk;

  pow2_clkdiv u0 (
    .clk(clk), .rst(rst), .add_req(a_add[0]), .sub_req(a_sub[0]), .amt(a_amt[0]),
    .div_en(w_en[0]), .exp_q(w_exp[0]), .stage_q(w_stg[0])
  );
  pow2_clkdiv #(.RST_EXP(12)) u1 (
    .clk(clk), .rst(rst), .add_req(a_add[1]), .sub_req(a_sub[1]), .amt(a_amt[1]),
    .div_en(w_en[1]), .exp_q(w_exp[1]), .stage_q(w_stg[1])
  );

  task automatic check(input string req, input int act, input int exp_v, input string what);
    n_chk++;
    if (act != exp_v) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  function automatic int eff(input int e);
    return (e > 9) ? 9 : e;
  endfunction

  // Drive one request for one cycle, update the model, compare.
  task automatic apply(input int w, input bit ad, input bit sb, input int amount, input string req);
    @(negedge clk);
    a_add[w] = ad; a_sub[w] = sb; a_amt[w] = 8'(amount);
    if (ad && !sb) begin
      if (m_stage[w] + amount > 255) begin
        if (eff(m_exp[w]) == 9) m_stage[w] = 255;
        else begin m_stage[w] = m_stage[w] + amount - 256; m_exp[w] = eff(m_exp[w]) + 1; end
      end else m_stage[w] = m_stage[w] + amount;
    end else if (sb && !ad) begin
      if (amount > m_stage[w]) begin
        if (eff(m_exp[w]) == 0) m_stage[w] = 0;
        else begin m_stage[w] = m_stage[w] - amount + 256; m_exp[w] = eff(m_exp[w]) - 1; end
      end else m_stage[w] = m_stage[w] - amount;
    end
    @(negedge clk);
    a_add[w] = 1'b0; a_sub[w] = 1'b0; a_amt[w] = 8'd0;
    check(req, int'(w_stg[w]), m_stage[w], "stage");
    check(req, int'(w_exp[w]), m_exp[w], "exponent");
  endtask

  task automatic gap_of(input int w, output int g);
    while (!w_en[w]) @(negedge clk);
    g = 0;
    do begin @(negedge clk); g++; end while (!w_en[w]);
  endtask

  task automatic check_period(input int w, input int expect_len, input string req);
    int g;
    gap_of(w, g);
    gap_of(w, g);
    check(req, g, expect_len, "pulse gap");
  endtask

  task automatic t_reset();
    check("R1", int'(w_stg[0]), 0, "stage after reset");
    check("R1", int'(w_exp[0]), 0, "exponent after reset");
    check("R1", int'(w_en[0]), 1, "pulse in first cycle");
    check_period(0, 1, "R1");
  endtask

  task automatic t_adds();
    apply(0, 1, 0, 5, "R4");
    apply(0, 1, 0, 32, "R4");
    apply(0, 1, 0, 230, "R5");
    check_period(0, 2, "R2");
    apply(0, 0, 1, 11, "R6");
    apply(0, 0, 1, 20, "R6");
    apply(0, 0, 1, 250, "R8");
    apply(0, 1, 1, 40, "R9");
    apply(0, 1, 0, 40, "R4");
    apply(0, 1, 1, 200, "R9");
    apply(0, 0, 1, 40, "R6");
  endtask

  task automatic t_climb();
    apply(0, 1, 0, 255, "R4");
    for (int k = 1; k <= 9; k++) begin
      apply(0, 1, 0, 255, "R5");
      check_period(0, 1 << k, "R2");
    end
    apply(0, 1, 0, 255, "R7");
    check_period(0, 512, "R7");
  endtask

  // Exponent drops 9 -> 8 in mid-period; old period must finish first.
  task automatic t_boundary();
    int g;
    apply(0, 0, 1, 255, "R6");
    while (!w_en[0]) @(negedge clk);
    repeat (3) @(negedge clk);
    apply(0, 0, 1, 1, "R6");
    g = 5;
    while (!w_en[0]) begin @(negedge clk); g++; end
    check("R10", g, 512, "gap spanning change");
    gap_of(0, g);
    check("R10", g, 256, "gap after change");
  endtask

  task automatic t_saturated();
    m_stage[1] = 0; m_exp[1] = 12;
    check("R3", int'(w_exp[1]), 12, "reset code");
    check_period(1, 512, "R3");
    apply(1, 1, 0, 255, "R3");
    apply(1, 1, 0, 1, "R3");
    apply(1, 0, 1, 1, "R3");
    apply(1, 0, 1, 255, "R3");
    check_period(1, 256, "R3");
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin
      a_add[w] = 1'b0; a_sub[w] = 1'b0; a_amt[w] = 8'd0;
      m_stage[w] = 0; m_exp[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_adds();
    t_climb();
    t_boundary();
    t_saturated();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule